// File: doc/BRIEF.md
# ADC Data-Ready and Status Sequencer

This block is the digital timing controller of a sampled data-acquisition front end. It runs on the system clock and advances its windows on a single-cycle timebase strobe, `tick`, which nominally arrives at 1 MHz. After power becomes good, the block spends a fixed initialization window doing nothing useful. During that window the interrupt pin carries a slow free-running square wave, which hosts are expected to disregard. When that window is over, the block waits for a host start command.

A start begins an analog settling window, with the interrupt held low. The block then enters continuous conversion, where each conversion period ends with a one-tick interrupt pulse. In the last few ticks before that pulse, the data-invalid window, the channel register takes the new sample from `sample_in` and the status register records that fresh data has arrived. Status clears only when the host reads it. Overrun and late reads are also tracked there. A read that arrives after the read window following an interrupt is reported as a late read.

Loss of power-good or a synchronous reset returns the block to initialization and clears the channel and status outputs.

Top module: `adc_ready_seq`

## Requirements
- R1: A synchronous `rst`, or `pwr_good` low, clears `chan_data`, `status` and `late_flag` to zero by the next clock edge and puts the block in initialization.
- R2: Initialization lasts INIT_TICKS ticks (default 500) with `pwr_good` high. A `start` during this window is ignored, so no interrupt follows it, and `status` stays 0.
- R3: During initialization `int_o` toggles once every OSC_DIV ticks (default 4), counted from the moment power-good returns. It is low on the first cycle.
- R4: A `start` seen while idle opens a settling window of STAB_TICKS ticks (default 1500), during which `int_o` stays low.
- R5: `chan_data` reads 0 until the first sample. It loads `sample_in` on the tick that opens the data-invalid window. That is tick PERIOD_TICKS−INVALID_TICKS of each period (default 992 after settling ends, i.e. 8 ticks before the interrupt). It changes at no other time.
- R6: `int_o` rises PERIOD_TICKS ticks (default 1000) after settling ends and then every PERIOD_TICKS ticks. Each pulse is exactly one tick wide.
- R7: `status` bit 0 (new data) is set on the edge the channel register loads. Bit 1 (overrun) is set when that load happens while bit 0 is still set.
- R8: `status` clears only on a status read (`rd_strobe` with `rd_sel`=1). A data read (`rd_sel`=0) leaves it unchanged.
- R9: A read in conversion after the first interrupt is late if more than RDWIN_TICKS ticks (default 100) have passed since the last interrupt. A read at exactly RDWIN_TICKS is not late. A late read gives a one-clock `late_flag` pulse on the next edge and sets `status` bit 2; this set wins over a clear in the same cycle.
- R10: Dropping `pwr_good` during conversion stops interrupts and data loads. When power returns, a full new initialization window must pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timebase strobe, one clock wide |
| pwr_good | input | 1 | Both supplies good |
| start | input | 1 | Host start command |
| rd_strobe | input | 1 | Host read, one clock wide |
| rd_sel | input | 1 | Read target: 0 channel data, 1 status |
| sample_in | input | DW | Next converted sample |
| int_o | output | 1 | Interrupt / init toggle |
| chan_data | output | DW | Channel data register |
| status | output | 3 | {late, overrun, new data} |
| late_flag | output | 1 | One-clock pulse on a late read |

## Verification
The bench drives `tick` high on every clock, so each window length equals a count of clock edges after the edge that sampled the stimulus. With defaults, the channel load is due 992 edges after settling ends, the interrupt is due 1000 edges after it, and the settling window lasts 1500 edges after the edge that sampled `start`. Status clearing and the late flag appear on the edge that samples the read. Each task moves a fixed number of edges from a known position. It samples one edge before and exactly at each due edge, reading outputs at the falling clock edge so that the outputs are settled there. The read-window boundary is checked on both sides: a read at 100 ticks after the interrupt and one at 101.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      PH_INIT = 2'd0,
      PH_IDLE = 2'd1,
      PH_STAB = 2'd2,
      PH_RUN  = 2'd3
   } seq_state_e;

   localparam int ST_W    = 3;
   localparam int ST_NEW  = 0;
   localparam int ST_OVR  = 1;
   localparam int ST_LATE = 2;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int INIT_TICKS = 500,
   parameter int STAB_TICKS = 1500
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tick,
   input  logic       pwr_good,
   input  logic       start,
   output seq_state_e state_o
);

   localparam int MAXW = (INIT_TICKS > STAB_TICKS) ? INIT_TICKS : STAB_TICKS;
   localparam int CW   = $clog2(MAXW + 1);
   localparam logic [CW-1:0] INIT_LAST = CW'(INIT_TICKS - 1);
   localparam logic [CW-1:0] STAB_LAST = CW'(STAB_TICKS - 1);

   seq_state_e    state_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !pwr_good) begin
         state_q <= PH_INIT;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            PH_INIT: if (tick) begin
               if (cnt_q == INIT_LAST) begin
                  state_q <= PH_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_IDLE: if (start) begin
               state_q <= PH_STAB;
               cnt_q   <= '0;
            end
            PH_STAB: if (tick) begin
               if (cnt_q == STAB_LAST) begin
                  state_q <= PH_RUN;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: cnt_q <= '0;
         endcase
      end
   end

   assign state_o = state_q;

   AST_IDLE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
      (state_q == PH_IDLE && !start && pwr_good) |=> state_q == PH_IDLE); // R4

endmodule

// File: rtl/adc_seq_osc.sv
module adc_seq_osc #(
   parameter int OSC_DIV = 4,
   parameter bit ENABLE  = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic active,
   output logic osc_o
);

   generate
      if (ENABLE) begin : g_toggle
         localparam int DW = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;
         localparam logic [DW-1:0] DIV_LAST = DW'(OSC_DIV - 1);
         logic [DW-1:0] div_q;
         logic          osc_q;

         always_ff @(posedge clk) begin
            if (rst || !active) begin
               div_q <= '0;
               osc_q <= 1'b0;
            end else if (tick) begin
               if (div_q == DIV_LAST) begin
                  div_q <= '0;
                  osc_q <= ~osc_q;
               end else begin
                  div_q <= div_q + 1'b1;
               end
            end
         end

         assign osc_o = osc_q;

         AST_OSC_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
            !active |=> !osc_q); // R3
      end else begin : g_quiet
         assign osc_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/adc_seq_period.sv
module adc_seq_period #(
   parameter int PERIOD_TICKS  = 1000,
   parameter int INVALID_TICKS = 8,
   parameter int RDWIN_TICKS   = 100
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic run,
   output logic upd_o,
   output logic int_o,
   output logic rd_open_o,
   output logic seen_o
);

   localparam int PW = $clog2(PERIOD_TICKS);
   localparam int RW = $clog2(RDWIN_TICKS + 1);
   localparam logic [PW-1:0] PH_LAST = PW'(PERIOD_TICKS - 1);
   localparam logic [PW-1:0] PH_UPD  = PW'(PERIOD_TICKS - INVALID_TICKS - 1);
   localparam logic [RW-1:0] RW_FULL = RW'(RDWIN_TICKS);

   logic [PW-1:0] phase_q;
   logic [RW-1:0] rw_q;
   logic          int_q;
   logic          seen_q;
   logic          end_ev;

   assign end_ev = run && tick && (phase_q == PH_LAST);
   assign upd_o  = run && tick && (phase_q == PH_UPD);

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         phase_q <= '0;
         rw_q    <= '0;
         int_q   <= 1'b0;
         seen_q  <= 1'b0;
      end else begin
         if (tick) phase_q <= end_ev ? '0 : phase_q + 1'b1;
         if (end_ev)    int_q <= 1'b1;
         else if (tick) int_q <= 1'b0;
         if (end_ev)                 rw_q <= RW_FULL;
         else if (tick && rw_q != 0) rw_q <= rw_q - 1'b1;
         if (end_ev) seen_q <= 1'b1;
      end
   end

   assign int_o     = int_q;
   assign rd_open_o = (rw_q != '0);
   assign seen_o    = seen_q;

   AST_INT_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
      (int_q && tick) |=> !int_q); // R6
   AST_UPD_NOT_AT_INT: assert property (@(posedge clk) disable iff (rst)
      upd_o |=> !int_q); // R5

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
   import adc_seq_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          pwr_good,
   input  seq_state_e    state,
   input  logic          upd,
   input  logic [DW-1:0] sample,
   input  logic          rd_strobe,
   input  logic          rd_sel,
   input  logic          rd_open,
   input  logic          seen,
   output logic [DW-1:0] chan_o,
   output logic [ST_W-1:0] status_o,
   output logic          late_o
);

   logic [DW-1:0]   chan_q;
   logic [ST_W-1:0] stat_q;
   logic            late_q;
   logic            clr;
   logic            late_ev;
   logic            wipe;

   assign wipe    = rst || !pwr_good || (state == PH_INIT);
   assign clr     = rd_strobe && rd_sel;
   assign late_ev = (state == PH_RUN) && rd_strobe && seen && !rd_open;

   always_ff @(posedge clk) begin
      if (wipe) begin
         chan_q <= '0;
         stat_q <= '0;
         late_q <= 1'b0;
      end else begin
         if (upd) chan_q <= sample;
         stat_q[ST_NEW]  <= upd | (stat_q[ST_NEW] & ~clr);
         stat_q[ST_OVR]  <= (upd & stat_q[ST_NEW] & ~clr) | (stat_q[ST_OVR] & ~clr);
         stat_q[ST_LATE] <= late_ev | (stat_q[ST_LATE] & ~clr);
         late_q          <= late_ev;
      end
   end

   assign chan_o   = chan_q;
   assign status_o = stat_q;
   assign late_o   = late_q;

   AST_CHAN_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (rst)
      !upd |=> (chan_q == $past(chan_q) || chan_q == '0)); // R5
   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
      !clr |=> ((stat_q & $past(stat_q)) == $past(stat_q) || stat_q == '0)); // R8
   AST_NO_LATE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
      (rd_strobe && rd_open) |=> !late_q); // R9

endmodule

// File: rtl/adc_ready_seq.sv
module adc_ready_seq
   import adc_seq_pkg::*;
#(
   parameter int DW            = 16,
   parameter int INIT_TICKS    = 500,
   parameter int STAB_TICKS    = 1500,
   parameter int PERIOD_TICKS  = 1000,
   parameter int INVALID_TICKS = 8,
   parameter int RDWIN_TICKS   = 100,
   parameter int OSC_DIV       = 4,
   parameter bit INIT_TOGGLE   = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick,
   input  logic          pwr_good,
   input  logic          start,
   input  logic          rd_strobe,
   input  logic          rd_sel,
   input  logic [DW-1:0] sample_in,
   output logic          int_o,
   output logic [DW-1:0] chan_data,
   output logic [2:0]    status,
   output logic          late_flag
);

   generate
      if (INVALID_TICKS < 1 || INVALID_TICKS >= PERIOD_TICKS) begin : g_bad_invalid
         $error("INVALID_TICKS must lie in 1..PERIOD_TICKS-1");
      end
      if (RDWIN_TICKS < 1 || RDWIN_TICKS + INVALID_TICKS >= PERIOD_TICKS) begin : g_bad_rdwin
         $error("read window must end before the data-invalid window");
      end
      if (INIT_TICKS < 1 || STAB_TICKS < 1 || OSC_DIV < 1 || DW < 1) begin : g_bad_misc
         $error("window lengths, OSC_DIV and DW must be positive");
      end
   endgenerate

   seq_state_e state;
   logic       run;
   logic       upd;
   logic       int_run;
   logic       rd_open;
   logic       seen;
   logic       osc;
   logic [ST_W-1:0] stat_w;

   adc_seq_ctrl #(
      .INIT_TICKS (INIT_TICKS),
      .STAB_TICKS (STAB_TICKS)
   ) i_ctrl (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .pwr_good (pwr_good),
      .start    (start),
      .state_o  (state)
   );

   assign run = (state == PH_RUN) && pwr_good;

   adc_seq_osc #(
      .OSC_DIV (OSC_DIV),
      .ENABLE  (INIT_TOGGLE)
   ) i_osc (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .active ((state == PH_INIT) && pwr_good),
      .osc_o  (osc)
   );

   adc_seq_period #(
      .PERIOD_TICKS  (PERIOD_TICKS),
      .INVALID_TICKS (INVALID_TICKS),
      .RDWIN_TICKS   (RDWIN_TICKS)
   ) i_period (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .run       (run),
      .upd_o     (upd),
      .int_o     (int_run),
      .rd_open_o (rd_open),
      .seen_o    (seen)
   );

   adc_seq_regs #(
      .DW (DW)
   ) i_regs (
      .clk       (clk),
      .rst       (rst),
      .pwr_good  (pwr_good),
      .state     (state),
      .upd       (upd),
      .sample    (sample_in),
      .rd_strobe (rd_strobe),
      .rd_sel    (rd_sel),
      .rd_open   (rd_open),
      .seen      (seen),
      .chan_o    (chan_data),
      .status_o  (stat_w),
      .late_o    (late_flag)
   );

   assign status = stat_w;
   assign int_o  = (state == PH_INIT) ? osc : int_run;

   AST_NO_INT_IN_STAB: assert property (@(posedge clk) disable iff (rst)
      (state == PH_STAB) |-> !int_o); // R4
   AST_NO_STATUS_IN_INIT: assert property (@(posedge clk) disable iff (rst)
      (state == PH_INIT) |-> (status == '0)); // R2
   AST_PWR_LOSS_CLEARS: assert property (@(posedge clk) disable iff (rst)
      !pwr_good |=> (chan_data == '0 && status == '0 && !late_flag)); // R1

endmodule

// File: tb/test_adc_ready_seq.sv
module test_adc_ready_seq;

   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          tick = 1'b1;
   logic          pwr_good = 1'b0;
   logic          start = 1'b0;
   logic          rd_strobe = 1'b0;
   logic          rd_sel = 1'b0;
   logic [DW-1:0] sample_in = '0;
   logic          int_o;
   logic [DW-1:0] chan_data;
   logic [2:0]    status;
   logic          late_flag;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   adc_ready_seq i_adc_ready_seq (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .pwr_good  (pwr_good),
      .start     (start),
      .rd_strobe (rd_strobe),
      .rd_sel    (rd_sel),
      .sample_in (sample_in),
      .int_o     (int_o),
      .chan_data (chan_data),
      .status    (status),
      .late_flag (late_flag)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic read(input logic sel);
      rd_sel    = sel;
      rd_strobe = 1'b1;
      edges(1);
      rd_strobe = 1'b0;
   endtask

   // R1: outputs at reset
   task automatic t_reset();
      @(negedge clk);
      rst = 1'b1; pwr_good = 1'b1;
      edges(3);
      check("R1 int", int_o, 0);
      check("R1 chan", chan_data, 0);
      check("R1 status", status, 0);
      check("R1 late", late_flag, 0);
      rst = 1'b0;
   endtask

   // R2, R3: init window with toggling and an ignored start
   task automatic t_init();
      int changes = 0;
      logic prev = int_o;
      for (int i = 1; i <= 499; i++) begin
         if (i == 100) start = 1'b1;
         edges(1);
         start = 1'b0;
         if (int_o !== prev) changes++;
         prev = int_o;
         if (status !== 3'd0) check("R2 status in init", status, 0);
      end
      check("R3 init toggles", changes, 124);
      edges(1);
      check("R2 idle int low", int_o, 0);
      begin
         int highs = 0;
         for (int i = 0; i < 2000; i++) begin
            edges(1);
            if (int_o) highs++;
         end
         check("R2 start in init ignored", highs, 0);
      end
      check("R2 status idle", status, 0);
   endtask

   // R4, R5, R6, R7, R8: settling then the first period
   task automatic t_first_period();
      int highs = 0;
      sample_in = 16'hA5C3;
      start = 1'b1;
      edges(1);
      start = 1'b0;
      for (int i = 0; i < 1500; i++) begin
         edges(1);
         if (int_o) highs++;
      end
      check("R4 no int in settling", highs, 0);
      edges(991);
      check("R5 chan zero before load", chan_data, 0);
      check("R7 status before load", status, 0);
      edges(1);
      check("R5 chan loaded", chan_data, 16'hA5C3);
      check("R7 new data", status, 3'b001);
      edges(7);
      check("R6 int not early", int_o, 0);
      edges(1);
      check("R6 first int", int_o, 1);
      read(1'b1);
      check("R6 one tick wide", int_o, 0);
      check("R8 status read clears", status, 0);
      check("R9 timely read", late_flag, 0);
   endtask

   // R5, R6, R7, R8, R9: overrun and the read-window edge
   task automatic t_overrun();
      sample_in = 16'h1234;
      edges(990);
      check("R5 chan stable", chan_data, 16'hA5C3);
      edges(1);
      check("R5 second load", chan_data, 16'h1234);
      check("R7 single new", status, 3'b001);
      sample_in = 16'h0F0F;
      edges(8);
      check("R6 periodic int", int_o, 1);
      edges(992);
      check("R5 third load", chan_data, 16'h0F0F);
      check("R7 overrun", status, 3'b011);
      edges(8);
      check("R6 third int", int_o, 1);
      edges(99);
      read(1'b0);
      check("R9 read at window edge not late", late_flag, 0);
      check("R8 data read keeps status", status, 3'b011);
   endtask

   // R9: a status read one tick past the window
   task automatic t_late();
      edges(1000);
      read(1'b1);
      check("R9 late pulse", late_flag, 1);
      check("R9 late bit after clear", status, 3'b100);
      edges(1);
      check("R9 pulse one clock", late_flag, 0);
   endtask

   // R10, R1, R3: power loss mid-run and recovery
   task automatic t_pwr_loss();
      int changes = 0;
      logic prev;
      pwr_good = 1'b0;
      edges(1);
      check("R1 pwr chan", chan_data, 0);
      check("R1 pwr status", status, 0);
      check("R10 pwr int", int_o, 0);
      edges(5);
      pwr_good = 1'b1;
      prev = int_o;
      for (int i = 0; i < 8; i++) begin
         edges(1);
         if (int_o !== prev) changes++;
         prev = int_o;
      end
      check("R3 toggle after pwr return", changes, 2);
      begin
         int highs = 0;
         start = 1'b1;
         edges(1);
         start = 1'b0;
         for (int i = 0; i < 3000; i++) begin
            edges(1);
            if (int_o && i > 500) highs++;
         end
         check("R10 fresh init ignores start", highs, 0);
      end
   endtask

   // R1: synchronous reset during conversion
   task automatic t_rst_mid();
      sample_in = 16'h5A5A;
      start = 1'b1;
      edges(1);
      start = 1'b0;
      edges(1500 + 992);
      check("R5 load after restart", chan_data, 16'h5A5A);
      rst = 1'b1;
      edges(1);
      check("R1 rst chan", chan_data, 0);
      check("R1 rst status", status, 0);
      check("R1 rst int", int_o, 0);
      rst = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_init();
      t_first_period();
      t_overrun();
      t_late();
      t_pwr_loss();
      t_rst_mid();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule